// File: doc/BRIEF.md
# Decorrelating stochastic stream splitter

The block accepts one unipolar stochastic bitstream, where a value x in [0,1] is carried as the fraction of ones in a run of bits. It produces N_LANES output streams. Each output has the same density of ones as the input, and the outputs are mutually independent. Copies made by fanning out a wire, or by delaying the stream through flip-flops, stay correlated with one another. Here each output is instead regenerated from a separate pseudo-random source, so that downstream gates see independent operands. The main use is an AND of two outputs, which then computes x squared and not x.

A density estimator counts the ones over a frame of 2^len_sel_i valid bits. At the end of the frame it scales that count to a 17-bit threshold, which it holds for the whole of the next frame. Every lane steps its own 16-bit maximal-length LFSR on each valid bit. A lane emits a one when the LFSR value does not exceed the threshold. A start-of-frame strobe re-aligns the frame boundary at any time. Outputs arrive one cycle after each valid input bit.

Top module: `stoch_splitter`

## Requirements
- R1: valid_o is high exactly one cycle after each cycle with valid_i high, and low otherwise. split_o changes only on the clock edge of a valid input bit and holds its value through idle cycles.
- R2: A frame is 2^len_sel_i valid bits, with len_sel_i clamped to the range 8..12. When a frame completes with k ones, the threshold becomes k * 2^(16 - len_sel_i), and it governs every output bit from the next valid input onward.
- R3: A valid bit with sof_i high is counted as the first bit of a new frame, and any partial count is discarded.
- R4: Between reset and the end of the first complete frame, the threshold is zero and every output bit is 0.
- R5: After a frame of all zeros, the next frame's outputs are all 0. After a frame of all ones, the next frame's outputs are all 1.
- R6: Each lane has a 16-bit maximal-length LFSR that is never zero. Lanes 0 to 3 use different feedback polynomials, and every lane has a different seed. Lane bit i is 1 when that lane's LFSR value is at most the threshold, so over a frame the ones count on each lane is within 0.16*L (L = 256) or 0.04*L (L = 4096) of the input's ones count.
- R7: Over a frame that follows an input frame of density x, the count of cycles in which split_o[0] and split_o[1] are both 1 is within the same tolerance of x*x*L.
- R8: Across x = 0.0, 0.1, ..., 1.0, the mean squared error of the measured AND density against x squared is below 6e-3 for L = 256 and below 1e-3 for L = 4096.
- R9: While reset is asserted and before any valid input, valid_o is 0 and split_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies bit_i in this cycle |
| sof_i | input | 1 | Marks bit_i as the first bit of a frame |
| bit_i | input | 1 | Serial stochastic input bit |
| len_sel_i | input | 4 | log2 of the frame length (8..12) |
| valid_o | output | 1 | Qualifies split_o |
| split_o | output | N_LANES | Regenerated output bits, one per lane |

## Verification
The input is driven as frames that carry an exact number of ones, round(x*L), at positions shuffled by a fixed-seed random generator, for eleven densities and both frame lengths.

- All-ones and all-zeros frames check the exact saturated outputs and the quiet period after reset.
- A truncated run of ones followed by a start-of-frame strobe separates a restarted frame from a frame that merely wrapped.
- The AND of two lanes at mid densities tells independent regeneration apart from plain copies: plain copies would give x instead of x squared.
- Idle gaps within a frame show that the outputs and the generators hold still.

// File: rtl/stoch_split_pkg.sv
package stoch_split_pkg;
  localparam int LFSR_W = 16;

  // Galois right-shift feedback masks of four maximal-length 16-bit polynomials
  function automatic logic [LFSR_W-1:0] lane_mask(input int idx);
    case (idx % 4)
      0:       return 16'hB400;
      1:       return 16'hD008;
      2:       return 16'h8805;
      default: return 16'h8016;
    endcase
  endfunction

  function automatic logic [LFSR_W-1:0] lane_seed(input int idx);
    logic [LFSR_W-1:0] s;
    s = 16'hACE1 ^ (16'(idx) * 16'h3B5D);
    if (s == '0) s = 16'h0001;
    return s;
  endfunction
endpackage

// File: rtl/stoch_density_est.sv
module stoch_density_est #(
  parameter int MIN_LOG2 = 8,
  parameter int MAX_LOG2 = 12,
  parameter int LFSR_W   = 16,
  localparam int SEL_W = $clog2(MAX_LOG2 + 1),
  localparam int CNT_W = MAX_LOG2,
  localparam int THR_W = LFSR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             bit_i,
  input  logic [SEL_W-1:0] len_sel_i,
  output logic [THR_W-1:0] thr_o
);
  logic [CNT_W-1:0] pos_q, idx, last_idx;
  logic [CNT_W:0]   ones_q, ones_nxt, full, full_m1;
  logic [THR_W-1:0] thr_q, thr_nxt;
  logic [SEL_W-1:0] len_eff;
  logic             frame_end;
  int               sh;

  always_comb begin
    if (len_sel_i < SEL_W'(MIN_LOG2))      len_eff = SEL_W'(MIN_LOG2);
    else if (len_sel_i > SEL_W'(MAX_LOG2)) len_eff = SEL_W'(MAX_LOG2);
    else                                   len_eff = len_sel_i;
    full      = (CNT_W+1)'(1) << len_eff;
    full_m1   = full - (CNT_W+1)'(1);
    last_idx  = full_m1[CNT_W-1:0];
    idx       = sof_i ? '0 : pos_q;
    ones_nxt  = ((idx == '0) ? '0 : ones_q) + (CNT_W+1)'(bit_i);
    frame_end = valid_i && (idx == last_idx);
    sh        = LFSR_W - int'(len_eff);
    thr_nxt   = THR_W'(ones_nxt) << sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      ones_q <= '0;
      thr_q  <= '0;
    end else if (valid_i) begin
      if (frame_end) begin
        pos_q  <= '0;
        ones_q <= '0;
        thr_q  <= thr_nxt;
      end else begin
        pos_q  <= idx + CNT_W'(1);
        ones_q <= ones_nxt;
      end
    end
  end

  assign thr_o = thr_q;

  // R2
  thr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q <= (THR_W'(1) << LFSR_W));
  // R2
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(thr_q));
  // R3
  sof_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (pos_q == CNT_W'(1)));
  // R2
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_idx);
endmodule

// File: rtl/stoch_lane.sv
module stoch_lane #(
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int THR_W = LFSR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             bit_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;
  logic              bit_q;

  always_comb begin
    lfsr_nxt = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? MASK : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= SEED;
      bit_q  <= 1'b0;
    end else if (valid_i) begin
      lfsr_q <= lfsr_nxt;
      bit_q  <= ({1'b0, lfsr_q} <= thr_i);
    end
  end

  assign bit_o = bit_q;

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  // R1
  lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(bit_q) && $stable(lfsr_q)));
endmodule

// File: rtl/stoch_splitter.sv
module stoch_splitter
  import stoch_split_pkg::*;
#(
  parameter int N_LANES  = 4,
  parameter int MIN_LOG2 = 8,
  parameter int MAX_LOG2 = 12,
  localparam int SEL_W = $clog2(MAX_LOG2 + 1),
  localparam int THR_W = LFSR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sof_i,
  input  logic               bit_i,
  input  logic [SEL_W-1:0]   len_sel_i,
  output logic               valid_o,
  output logic [N_LANES-1:0] split_o
);
  logic [THR_W-1:0] thr;
  logic             valid_q;

  stoch_density_est #(
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2),
    .LFSR_W  (LFSR_W)
  ) u_est (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sof_i    (sof_i),
    .bit_i    (bit_i),
    .len_sel_i(len_sel_i),
    .thr_o    (thr)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    stoch_lane #(
      .LFSR_W(LFSR_W),
      .MASK  (lane_mask(g)),
      .SEED  (lane_seed(g))
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .thr_i  (thr),
      .bit_o  (split_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R4
  zero_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && thr == '0) |=> (split_o == '0));
  // R5
  full_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && thr == (THR_W'(1) << LFSR_W)) |=> (&split_o));
endmodule

// File: tb/stoch_splitter_test.sv
`timescale 1ns/1ps
module stoch_splitter_test;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, sof_i = 1'b0, bit_i = 1'b0;
  logic [3:0]    len_sel_i = 4'd8;
  logic          valid_o;
  logic [NL-1:0] split_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cnt_lane [NL];
  int cnt_and = 0, cnt_tot = 0;
  bit arr [0:4095];

  always #5 clk = ~clk;

  stoch_splitter #(.N_LANES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .bit_i(bit_i), .len_sel_i(len_sel_i), .valid_o(valid_o), .split_o(split_o)
  );

  initial for (int l = 0; l < NL; l++) cnt_lane[l] = 0;

  // cumulative output counters, sampled 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_ni && valid_o) begin
      for (int l = 0; l < NL; l++) cnt_lane[l] += int'(split_o[l]);
      cnt_and += int'(split_o[0] & split_o[1]);
      cnt_tot++;
    end
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0f expected=%0f", req, act, exp);
    end
  endtask

  task automatic drive_frame(input int k, input int len);
    for (int j = 0; j < len; j++) arr[j] = (j < k);
    for (int j = len - 1; j > 0; j--) begin
      int r;
      bit t;
      r = int'($urandom % (j + 1));
      t = arr[j]; arr[j] = arr[r]; arr[r] = t;
    end
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      valid_i = 1'b1; sof_i = (j == 0); bit_i = arr[j];
    end
    @(negedge clk);
    valid_i = 1'b0; sof_i = 1'b0; bit_i = 1'b0;
  endtask

  // drives a shaping frame, then a measured frame of the same density
  task automatic measure(input int k, input int len, output int lanes [NL], output int andc, output int tot);
    int l0 [NL];
    int a0, t0;
    drive_frame(k, len);
    for (int l = 0; l < NL; l++) l0[l] = cnt_lane[l];
    a0 = cnt_and; t0 = cnt_tot;
    drive_frame(k, len);
    @(negedge clk);
    for (int l = 0; l < NL; l++) lanes[l] = cnt_lane[l] - l0[l];
    andc = cnt_and - a0;
    tot = cnt_tot - t0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lanes [NL];
    int andc, tot, snap;
    logic [NL-1:0] held;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(valid_o == 1'b0 && split_o == '0, "R9 reset", real'(split_o), 0.0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && split_o == '0, "R9 idle after reset", real'(split_o), 0.0);

    // R4 first frame (all ones) yields only zeros
    snap = cnt_lane[0] + cnt_lane[1] + cnt_lane[2] + cnt_lane[3];
    drive_frame(256, 256);
    @(negedge clk);
    check(cnt_lane[0] + cnt_lane[1] + cnt_lane[2] + cnt_lane[3] - snap == 0,
          "R4 pre-frame zeros", real'(cnt_lane[0] + cnt_lane[1] + cnt_lane[2] + cnt_lane[3] - snap), 0.0);

    // R5 all ones after an all-ones frame
    measure(256, 256, lanes, andc, tot);
    check(tot == 256, "R1 valid count", real'(tot), 256.0);
    for (int l = 0; l < NL; l++)
      check(lanes[l] == 256, "R5 all ones", real'(lanes[l]), 256.0);

    // R1 gap: outputs hold, valid_o low
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); valid_i = 1'b1; sof_i = (j == 0); bit_i = 1'b1;
    end
    @(negedge clk); valid_i = 1'b0; sof_i = 1'b0;
    held = split_o;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid_o low in gap", real'(valid_o), 0.0);
    check(split_o == held, "R1 outputs hold in gap", real'(split_o), real'(held));

    // R3 partial run of ones discarded by sof, then zero frame
    for (int j = 0; j < 100; j++) begin
      @(negedge clk); valid_i = 1'b1; sof_i = (j == 0); bit_i = 1'b1;
    end
    drive_frame(0, 256);
    snap = cnt_lane[0] + cnt_lane[1] + cnt_lane[2] + cnt_lane[3];
    drive_frame(0, 256);
    @(negedge clk);
    check(cnt_lane[0] + cnt_lane[1] + cnt_lane[2] + cnt_lane[3] - snap == 0,
          "R3 sof restart / R5 all zeros",
          real'(cnt_lane[0] + cnt_lane[1] + cnt_lane[2] + cnt_lane[3] - snap), 0.0);

    // R2 R6 R7 R8 density sweep at both frame lengths
    for (int s = 0; s < 2; s++) begin
      int  len;
      real tol, mse, lim;
      len = (s == 0) ? 256 : 4096;
      tol = (s == 0) ? 0.16 : 0.04;
      lim = (s == 0) ? 6e-3 : 1e-3;
      len_sel_i = (s == 0) ? 4'd8 : 4'd12;
      mse = 0.0;
      for (int i = 0; i <= 10; i++) begin
        int  k;
        real x, ex, got;
        k = (i * len + 5) / 10;
        x = real'(k) / real'(len);
        measure(k, len, lanes, andc, tot);
        check(tot == len, "R2 frame length", real'(tot), real'(len));
        for (int l = 0; l < NL; l++) begin
          got = real'(lanes[l]) - real'(k);
          if (got < 0.0) got = -got;
          check(got <= tol * len, "R6 lane density", real'(lanes[l]), real'(k));
        end
        ex = x * x * len;
        got = real'(andc) - ex;
        if (got < 0.0) got = -got;
        check(got <= tol * len, "R7 and equals square", real'(andc), ex);
        got = real'(andc) / real'(len) - x * x;
        mse += got * got;
      end
      mse = mse / 11.0;
      check(mse < lim, "R8 mean squared error", mse, lim);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule